// File: doc/BRIEF.md
# Host Interrupt Mask Controller for a Block-Transfer Management Interface

This block owns the two-bit interrupt mask register of a block-transfer style management interface and drives the single level-sensitive host interrupt. Bit 0 of the register is the interrupt enable and bit 1 is the interrupt-pending flag. The interrupt output follows the pending flag. The host reads the register through `mask_rd_o` and writes it with a one-cycle `host_wr_i` strobe. Bit 1 is write-one-to-clear. Writing bit 0 changes the enable, and a rising enable can raise the interrupt.

The controller side sends single-cycle events. A response-ready pulse means the controller has just set its controller-to-host attention flag. An SMS-attention event carries a new flag value and a flag that asks for an interrupt. The current attention levels, a global interrupt enable and a strap that says an interrupt line is wired come in as plain inputs. The attention flags are kept outside this block. The interrupt is raised only on transitions: the enable rising while attention is active, or a new event arriving while nothing is pending. SMS attention never raises or drops the line while controller-to-host attention is in force.

When a host write and an event fall in the same cycle, the write is applied first. The event is then judged against the enable as the write left it. A cold reset pulse clears the register. A warm reset pulse leaves it unchanged.

Top module: `bt_irq_mask_ctrl`

## Requirements
- R1: After `rst_ni` is released, the enable and pending flags are 0, `irq_o` is 0 and all of `mask_rd_o` reads 0.
- R2: `mask_rd_o` bit 0 is the enable, bit 1 is the pending flag and the upper bits read 0. `irq_o` equals the pending flag at all times, and pending is never 1 while the enable is 0.
- R3: A host write whose bit 0 is 1 while the enable is 0 stores enable 1. It also sets pending if `b2h_atn_i` or `sms_atn_i` is 1, whatever the global enable and the present strap are. Otherwise pending stays 0.
- R4: A host write whose bit 0 is 0 while the enable is 1 stores enable 0 and clears pending.
- R5: In a host write, bit 1 = 1 clears pending. This happens after any set from R3 in the same write, so a write of 2'b11 leaves pending at 0. Bit 1 = 0 leaves pending as it is, and a write whose bit 0 equals the enable leaves the enable as it is.
- R6: A `rsp_ready_i` pulse sets pending when `irq_present_i`, `irq_glb_en_i` and the enable are all 1. Otherwise it does not change the register.
- R7: An `sms_evt_i` pulse with `sms_val_i` = 1 while `sms_atn_i` = 0 sets pending only if `sms_irq_req_i`, `irq_present_i`, `irq_glb_en_i` and the enable are 1 and controller-to-host attention is off. That attention counts as on when `b2h_atn_i` or `rsp_ready_i` is 1. An event whose `sms_val_i` equals `sms_atn_i` has no effect.
- R8: An `sms_evt_i` pulse with `sms_val_i` = 0 while `sms_atn_i` = 1 clears pending only when controller-to-host attention is off, as defined in R7.
- R9: A `cold_rst_i` pulse clears both enable and pending, whatever else happens in the same cycle. A `warm_rst_i` pulse leaves the register unchanged.
- R10: When a host write and an event arrive in the same cycle, the event is evaluated against the enable and pending values the write produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| host_wr_i | input | 1 | Host write strobe to the mask register |
| host_wdata_i | input | DW | Host write data (bit 0 enable, bit 1 clear-pending) |
| rsp_ready_i | input | 1 | Pulse: response ready, controller-to-host attention just set |
| sms_evt_i | input | 1 | Pulse: SMS attention change request |
| sms_val_i | input | 1 | New SMS attention value for the event |
| sms_irq_req_i | input | 1 | SMS event asks for an interrupt |
| b2h_atn_i | input | 1 | Current controller-to-host attention flag |
| sms_atn_i | input | 1 | Current SMS attention flag (before the event) |
| irq_glb_en_i | input | 1 | Global interrupt enable |
| irq_present_i | input | 1 | Strap: an interrupt line is wired |
| cold_rst_i | input | 1 | Pulse: cold reset of the register |
| warm_rst_i | input | 1 | Pulse: warm reset (no effect on the register) |
| irq_o | output | 1 | Level-sensitive host interrupt |
| mask_rd_o | output | DW | Mask register read value |

## Verification
The assertions assume that the event inputs are one-cycle pulses and that `sms_atn_i` and `b2h_atn_i` show the attention flags as they stood before the event in that cycle. They also assume that the write data is stable while `host_wr_i` is high. The stimulus drives every strobe and pulse for exactly one cycle, from the falling edge, and returns it to 0 before the next one. It sets the attention levels only together with the event that they qualify. The sweep starts from each reachable register state in turn and drives every combination of write, data, events, attention levels and qualifiers.

// File: rtl/bt_irq_pkg.sv
package bt_irq_pkg;
   localparam int MASK_EN_POS   = 0;
   localparam int MASK_PEND_POS = 1;
   localparam int MASK_BITS     = 2;

   typedef struct packed {
      logic pend;
      logic en;
   } irq_mask_t;
endpackage

// File: rtl/bt_irq_host_wr.sv
module bt_irq_host_wr
   import bt_irq_pkg::*;
(
   input  irq_mask_t cur_i,
   input  logic      wr_i,
   input  logic      wd_en_i,
   input  logic      wd_clr_i,
   input  logic      b2h_atn_i,
   input  logic      sms_atn_i,
   output irq_mask_t nxt_o
);
   always_comb begin
      nxt_o = cur_i;
      if (wr_i) begin
         if (wd_en_i != cur_i.en) begin
            if (wd_en_i) begin
               if (b2h_atn_i || sms_atn_i) nxt_o.pend = 1'b1;
               nxt_o.en = 1'b1;
            end else begin
               nxt_o.pend = 1'b0;
               nxt_o.en   = 1'b0;
            end
         end
         if (wd_clr_i) nxt_o.pend = 1'b0;
      end
   end
endmodule

// File: rtl/bt_irq_evt.sv
module bt_irq_evt
   import bt_irq_pkg::*;
(
   input  irq_mask_t cur_i,
   input  logic      rsp_i,
   input  logic      sms_evt_i,
   input  logic      sms_val_i,
   input  logic      sms_req_i,
   input  logic      b2h_atn_i,
   input  logic      sms_atn_i,
   input  logic      glb_en_i,
   input  logic      present_i,
   input  logic      cold_i,
   output irq_mask_t nxt_o
);
   logic b2h_eff;
   logic line_ok;
   logic sms_change;

   assign b2h_eff    = b2h_atn_i | rsp_i;
   assign line_ok    = present_i & glb_en_i;
   assign sms_change = sms_evt_i & (sms_val_i != sms_atn_i);

   always_comb begin
      nxt_o = cur_i;
      if (rsp_i && line_ok && cur_i.en && !cur_i.pend)
         nxt_o.pend = 1'b1;
      if (sms_change) begin
         if (sms_val_i) begin
            if (sms_req_i && line_ok && cur_i.en && !b2h_eff)
               nxt_o.pend = 1'b1;
         end else if (!b2h_eff) begin
            nxt_o.pend = 1'b0;
         end
      end
      if (cold_i) begin
         nxt_o.en   = 1'b0;
         nxt_o.pend = 1'b0;
      end
   end
endmodule

// File: rtl/bt_irq_state.sv
module bt_irq_state
   import bt_irq_pkg::*;
#(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  irq_mask_t d_i,
   output irq_mask_t q_o
);
   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q_o <= '0;
            else         q_o <= d_i;
         end
      end else begin : g_sync
         always_ff @(posedge clk_i) begin
            if (!rst_ni) q_o <= '0;
            else         q_o <= d_i;
         end
      end
   endgenerate
endmodule

// File: rtl/bt_irq_mask_ctrl.sv
module bt_irq_mask_ctrl
   import bt_irq_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          host_wr_i,
   input  logic [DW-1:0] host_wdata_i,
   input  logic          rsp_ready_i,
   input  logic          sms_evt_i,
   input  logic          sms_val_i,
   input  logic          sms_irq_req_i,
   input  logic          b2h_atn_i,
   input  logic          sms_atn_i,
   input  logic          irq_glb_en_i,
   input  logic          irq_present_i,
   input  logic          cold_rst_i,
   input  logic          warm_rst_i,
   output logic          irq_o,
   output logic [DW-1:0] mask_rd_o
);
   localparam int PAD_W = DW - MASK_BITS;

   generate
      if (DW < MASK_BITS) begin : g_bad_dw
         $error("bt_irq_mask_ctrl: DW must be at least MASK_BITS");
      end
   endgenerate

   irq_mask_t state_q;
   irq_mask_t after_wr;
   irq_mask_t after_evt;

   logic          warm_unused;
   logic [DW-1:0] wdata_unused;
   assign warm_unused  = warm_rst_i;
   assign wdata_unused = host_wdata_i;

   bt_irq_host_wr u_wr (
      .cur_i     (state_q),
      .wr_i      (host_wr_i),
      .wd_en_i   (host_wdata_i[MASK_EN_POS]),
      .wd_clr_i  (host_wdata_i[MASK_PEND_POS]),
      .b2h_atn_i (b2h_atn_i),
      .sms_atn_i (sms_atn_i),
      .nxt_o     (after_wr)
   );

   bt_irq_evt u_evt (
      .cur_i     (after_wr),
      .rsp_i     (rsp_ready_i),
      .sms_evt_i (sms_evt_i),
      .sms_val_i (sms_val_i),
      .sms_req_i (sms_irq_req_i),
      .b2h_atn_i (b2h_atn_i),
      .sms_atn_i (sms_atn_i),
      .glb_en_i  (irq_glb_en_i),
      .present_i (irq_present_i),
      .cold_i    (cold_rst_i),
      .nxt_o     (after_evt)
   );

   bt_irq_state #(.ASYNC_RST(ASYNC_RST)) u_state (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (after_evt),
      .q_o    (state_q)
   );

   assign irq_o = state_q.pend;

   generate
      if (PAD_W > 0) begin : g_pad
         assign mask_rd_o = {{PAD_W{1'b0}}, state_q.pend, state_q.en};
      end else begin : g_nopad
         assign mask_rd_o = {state_q.pend, state_q.en};
      end
   endgenerate

   // R2
   pend_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> mask_rd_o[MASK_EN_POS]);

   // R4
   en_fall_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_wr_i && !host_wdata_i[MASK_EN_POS] && mask_rd_o[MASK_EN_POS])
      |=> (!irq_o && !mask_rd_o[MASK_EN_POS]));

   // R5
   w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_wr_i && host_wdata_i[MASK_PEND_POS] && !rsp_ready_i && !sms_evt_i)
      |=> !irq_o);

   // R6
   rsp_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!host_wr_i && !cold_rst_i && rsp_ready_i && irq_present_i && irq_glb_en_i
       && mask_rd_o[MASK_EN_POS]) |=> irq_o);

   // R9
   cold_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cold_rst_i |=> (mask_rd_o == '0));

   // R9
   warm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_rst_i && !host_wr_i && !rsp_ready_i && !sms_evt_i && !cold_rst_i)
      |=> $stable(mask_rd_o));
endmodule

// File: tb/bt_irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module bt_irq_mask_ctrl_test;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr = 1'b0;
   logic [DW-1:0] wd = '0;
   logic rsp = 0, sevt = 0, sval = 0, sreq = 0, b2h = 0, satn = 0;
   logic glb = 0, pres = 0, cold = 0, warm = 0;
   logic          irq;
   logic [DW-1:0] mrd;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bt_irq_mask_ctrl #(.DW(DW)) uut (
      .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_wdata_i(wd),
      .rsp_ready_i(rsp), .sms_evt_i(sevt), .sms_val_i(sval),
      .sms_irq_req_i(sreq), .b2h_atn_i(b2h), .sms_atn_i(satn),
      .irq_glb_en_i(glb), .irq_present_i(pres), .cold_rst_i(cold),
      .warm_rst_i(warm), .irq_o(irq), .mask_rd_o(mrd)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      wr = 0; wd = '0; rsp = 0; sevt = 0; sval = 0; sreq = 0;
      b2h = 0; satn = 0; glb = 0; pres = 0; cold = 0; warm = 0;
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   // Expected {pend, en} after one cycle, built from R3..R10
   function automatic logic [1:0] model(input logic en, input logic pd,
      input logic w, input logic d0, input logic d1, input logic r,
      input logic se, input logic sv, input logic sq, input logic bh,
      input logic sa, input logic g, input logic p);
      logic e2, p2, bon;
      e2 = en; p2 = pd;
      if (w) begin
         if (d0 && !en) begin e2 = 1; p2 = bh | sa; end
         if (!d0 && en) begin e2 = 0; p2 = 0; end
         if (d1) p2 = 0;
      end
      bon = bh | r;
      if (r && p && g && e2) p2 = 1;
      if (se && sv && !sa && sq && p && g && e2 && !bon) p2 = 1;
      if (se && !sv && sa && !bon) p2 = 0;
      return {p2, e2};
   endfunction

   function automatic string tag(input logic w, input logic r, input logic se, input logic sv);
      if (w && (r || se)) return "R10";
      if (r)              return "R6";
      if (se && sv)       return "R7";
      if (se)             return "R8";
      if (w)              return "R5";
      return "R2";
   endfunction

   // setup: 0 = idle, 1 = enabled, 2 = enabled and pending
   task automatic set_state(input int s);
      idle(); cold = 1; cyc();
      idle();
      if (s > 0) begin wr = 1; wd = 8'h01; b2h = (s == 2); end
      cyc();
      idle(); cyc();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      idle();
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      // R1 reset state
      chk("R1", mrd, '0);
      chk("R1", {7'd0, irq}, '0);

      // R3 enable rise with only SMS attention, line absent
      wr = 1; wd = 8'h01; satn = 1; cyc(); idle();
      chk("R3", mrd, 8'h03);
      chk("R2", {7'd0, irq}, 8'h01);
      // R9 warm reset: no effect
      warm = 1; cyc(); idle();
      chk("R9", mrd, 8'h03);
      // R9 cold reset wins over same-cycle response
      cold = 1; rsp = 1; pres = 1; glb = 1; cyc(); idle();
      chk("R9", mrd, 8'h00);
      // R5 write 2'b11 with attention active: enable set, pending cleared
      wr = 1; wd = 8'h03; b2h = 1; cyc(); idle();
      chk("R5", mrd, 8'h01);
      // R7 repeated SMS value does nothing
      sevt = 1; sval = 1; satn = 1; sreq = 1; pres = 1; glb = 1; cyc(); idle();
      chk("R7", mrd, 8'h01);
      // R6 response raises
      rsp = 1; pres = 1; glb = 1; cyc(); idle();
      chk("R6", mrd, 8'h03);
      // R4 enable fall clears pending
      wr = 1; wd = 8'h00; cyc(); idle();
      chk("R4", mrd, 8'h00);
      // R10 write enable plus response in the same cycle
      wr = 1; wd = 8'h01; rsp = 1; pres = 1; glb = 1; cyc(); idle();
      chk("R10", mrd, 8'h03);

      // near-exhaustive sweep
      for (int s = 0; s < 3; s++) begin
         for (int v = 0; v < 2048; v++) begin
            logic [10:0] b;
            logic [1:0]  e;
            b = v[10:0];
            set_state(s);
            wr = b[0]; wd = {6'd0, b[2], b[1]}; rsp = b[3]; sevt = b[4];
            sval = b[5]; sreq = b[6]; b2h = b[7]; satn = b[8];
            glb = b[9]; pres = b[10];
            e = model(s > 0, s == 2, b[0], b[1], b[2], b[3], b[4], b[5],
                      b[6], b[7], b[8], b[9], b[10]);
            cyc();
            idle();
            chk(tag(b[0], b[3], b[4], b[5]), mrd, {6'd0, e});
            chk("R2", {7'd0, irq}, {7'd0, e[1]});
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule